// File: doc/BRIEF.md
# Speculative Return Address Stack

This block predicts the targets of subroutine returns for the fetch stage of a branch predictor. A call pushes its return address, which is the call's own address plus a fixed instruction size. A return reads the top entry as its predicted target and then pops it. The stack is circular. When the stack is full, a new push overwrites the oldest entry, so the most recent call history always survives.

Fetch runs ahead of execution, so pushes and pops are speculative and must be repairable. For every return, the predictor saves the top index and top value it saw before the pop. If that return is later squashed, the restore port takes the saved pair back in one cycle. It moves the top pointer to the saved index and rewrites that slot with the saved target, so an entry overwritten by a younger push is recovered exactly. A squashed call is undone with the separate undo-pop input, which removes the entry that the call pushed.

Occupancy is tracked by a three-state controller:
- `S_EMPTY`: no entries.
- `S_PART`: between one and DEPTH-1 entries.
- `S_FULL`: DEPTH entries.

The transitions are:
- `T_FILL`: push or restore from `S_EMPTY` to `S_PART`.
- `T_TOPUP`: push reaching DEPTH, from `S_PART` to `S_FULL`.
- `T_DRAIN`: pop of the last entry, from `S_PART` to `S_EMPTY`.
- `T_SPILL`: pop from `S_FULL` to `S_PART`.
- `T_HOLD`: every other case keeps the state.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, `empty_o` is 1, `top_idx_o` is 0 and `top_addr_o` is 0.
- R2: A push writes `call_pc_i + INSN_BYTES` into slot `top_idx_o + 1` (modulo DEPTH) and advances `top_idx_o` to that slot. Both changes are visible the cycle after the push.
- R3: While the stack is not empty, `top_addr_o` shows the top slot, and `ret_hit_o` is 1 in any cycle where `ret_pop_i` is 1. A return pop decrements `top_idx_o` modulo DEPTH on the next cycle.
- R4: While the stack is empty, `top_addr_o` is 0 and `ret_hit_o` is 0 even with `ret_pop_i` high. A pop on an empty stack leaves `top_idx_o` and `empty_o` unchanged.
- R5: `undo_pop_i` pops exactly like a return pop. If `undo_pop_i` and `ret_pop_i` are both high in one cycle, the stack pops once.
- R6: A restore sets `top_idx_o` to `rst_idx_i` and writes `rst_tgt_i` into that slot. The stack is non-empty afterwards. The entry count becomes 1 if the stack was empty and is otherwise kept.
- R7: The pointer wraps modulo DEPTH, and DEPTH must be a power of two. A push when the stack holds DEPTH entries overwrites the oldest slot, and the count stays at DEPTH.
- R8: Priority within one cycle is restore first, then push, then pop. The lower-priority requests in that cycle are ignored.
- R9: `empty_o` is 1 exactly when the entry count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_push_i | input | 1 | Push the return address of a call |
| call_pc_i | input | ADDR_W | Address of the call instruction |
| ret_pop_i | input | 1 | Return seen: predict from top, then pop |
| undo_pop_i | input | 1 | Pop that cancels a squashed call push |
| restore_i | input | 1 | Repair from a saved checkpoint |
| rst_idx_i | input | PTR_W | Saved top index |
| rst_tgt_i | input | ADDR_W | Saved top target |
| top_addr_o | output | ADDR_W | Predicted return target, 0 when empty |
| top_idx_o | output | PTR_W | Current top index, for checkpointing |
| ret_hit_o | output | 1 | Return predicted taken with a valid target |
| empty_o | output | 1 | No valid entries |

## Verification
The collision that matters is a repair arriving in the same cycle as new speculative traffic: a restore together with a push or a return pop, and also a push together with a pop. The bench drives these overlaps on purpose, including a restore issued while the stack is full and a push that lands on a full stack and wraps. After each cycle it compares the index, target, hit and empty outputs against a behavioural model that applies restore, then push, then pop. A stream of mixed random operations follows the directed cases, so collisions also occur at arbitrary occupancies.

// File: rtl/ras_pkg.sv
package ras_pkg;
    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_PART  = 2'd1,
        S_FULL  = 2'd2
    } occ_state_e;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_RESTORE = 2'd1,
        OP_PUSH    = 2'd2,
        OP_POP     = 2'd3
    } ras_op_e;
endpackage

// File: rtl/ras_op_arb.sv
module ras_op_arb
    import ras_pkg::*;
(
    input  logic    push_req,
    input  logic    ret_req,
    input  logic    undo_req,
    input  logic    restore_req,
    output ras_op_e op
);
    // restore beats push beats any pop; two pop requests merge into one
    always_comb begin
        if (restore_req)             op = OP_RESTORE;
        else if (push_req)           op = OP_PUSH;
        else if (ret_req || undo_req) op = OP_POP;
        else                         op = OP_NONE;
    end
endmodule

// File: rtl/ras_occ_ctrl.sv
module ras_occ_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ras_op_e          op,
    input  logic [PTR_W-1:0] rst_idx,
    output logic [PTR_W-1:0] ptr,
    output logic             is_empty,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic             wr_from_restore
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    occ_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_EMPTY;
            cnt_q   <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ptr_q   <= ptr_d;
        end
    end

    // next state, count and pointer
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            S_EMPTY: begin
                if (op == OP_RESTORE || op == OP_PUSH) begin   // T_FILL
                    state_d = S_PART;
                    cnt_d   = CNT_ONE;
                end
            end
            S_PART: begin
                if (op == OP_PUSH) begin
                    cnt_d = cnt_q + CNT_ONE;
                    if (cnt_q + CNT_ONE == CNT_MAX) state_d = S_FULL; // T_TOPUP
                end else if (op == OP_POP) begin
                    cnt_d = cnt_q - CNT_ONE;
                    if (cnt_q == CNT_ONE) state_d = S_EMPTY;        // T_DRAIN
                end
            end
            S_FULL: begin
                if (op == OP_POP) begin                            // T_SPILL
                    state_d = S_PART;
                    cnt_d   = cnt_q - CNT_ONE;
                end
            end
            default: begin
                state_d = S_EMPTY;
                cnt_d   = '0;
            end
        endcase
        unique case (op)
            OP_RESTORE: ptr_d = rst_idx;
            OP_PUSH:    ptr_d = ptr_q + PTR_W'(1);
            OP_POP:     if (state_q != S_EMPTY) ptr_d = ptr_q - PTR_W'(1);
            OP_NONE:    ptr_d = ptr_q;
            default:    ptr_d = ptr_q;
        endcase
    end

    // outputs
    always_comb begin
        ptr             = ptr_q;
        is_empty        = (state_q == S_EMPTY);
        wr_en           = (op == OP_RESTORE) || (op == OP_PUSH);
        wr_from_restore = (op == OP_RESTORE);
        wr_idx          = (op == OP_RESTORE) ? rst_idx : ptr_q + PTR_W'(1);
    end
endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  widx,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [PTR_W-1:0]  ridx,
    output logic [ADDR_W-1:0] rdata
);
    logic [ADDR_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slots[widx] <= wdata;
    end

    assign rdata = slots[ridx];
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DEPTH      = 16,
    parameter int INSN_BYTES = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_push_i,
    input  logic [ADDR_W-1:0] call_pc_i,
    input  logic              ret_pop_i,
    input  logic              undo_pop_i,
    input  logic              restore_i,
    input  logic [PTR_W-1:0]  rst_idx_i,
    input  logic [ADDR_W-1:0] rst_tgt_i,
    output logic [ADDR_W-1:0] top_addr_o,
    output logic [PTR_W-1:0]  top_idx_o,
    output logic              ret_hit_o,
    output logic              empty_o
);
    ras_op_e           op;
    logic [PTR_W-1:0]  ptr, wr_idx;
    logic              is_empty, wr_en, wr_from_restore;
    logic [ADDR_W-1:0] wr_data, rd_data;

    ras_op_arb u_arb (
        .push_req    (call_push_i),
        .ret_req     (ret_pop_i),
        .undo_req    (undo_pop_i),
        .restore_req (restore_i),
        .op          (op)
    );

    ras_occ_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .op              (op),
        .rst_idx         (rst_idx_i),
        .ptr             (ptr),
        .is_empty        (is_empty),
        .wr_en           (wr_en),
        .wr_idx          (wr_idx),
        .wr_from_restore (wr_from_restore)
    );

    assign wr_data = wr_from_restore ? rst_tgt_i
                                     : call_pc_i + ADDR_W'(INSN_BYTES);

    ras_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .widx  (wr_idx),
        .wdata (wr_data),
        .ridx  (ptr),
        .rdata (rd_data)
    );

    assign top_addr_o = is_empty ? '0 : rd_data;
    assign top_idx_o  = ptr;
    assign empty_o    = is_empty;
    assign ret_hit_o  = ret_pop_i && !is_empty;
endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
    parameter int ADDR_W     = 32,
    parameter int DEPTH      = 16,
    parameter int INSN_BYTES = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              call_push_i,
    input logic [ADDR_W-1:0] call_pc_i,
    input logic              ret_pop_i,
    input logic              undo_pop_i,
    input logic              restore_i,
    input logic [PTR_W-1:0]  rst_idx_i,
    input logic [ADDR_W-1:0] rst_tgt_i,
    input logic [ADDR_W-1:0] top_addr_o,
    input logic [PTR_W-1:0]  top_idx_o,
    input logic              ret_hit_o,
    input logic              empty_o
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= rst_n;

    AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (call_push_i && !restore_i) |=> (top_idx_o == PTR_W'($past(top_idx_o) + 1)
            && top_addr_o == $past(call_pc_i) + ADDR_W'(INSN_BYTES) && !empty_o)); // R2

    AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (!ret_hit_o && top_addr_o == '0)); // R4

    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (empty_o && !call_push_i && !restore_i) |=> ($stable(top_idx_o) && empty_o)); // R4

    AST_RESTORE_EXACT: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        restore_i |=> (top_idx_o == $past(rst_idx_i)
            && top_addr_o == $past(rst_tgt_i) && !empty_o)); // R6

    AST_HIT_WHEN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pop_i && !empty_o) |-> ret_hit_o); // R3

    AST_POP_STEPS_BACK: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ((ret_pop_i || undo_pop_i) && !empty_o && !call_push_i && !restore_i)
            |=> top_idx_o == PTR_W'($past(top_idx_o) - 1)); // R5
endmodule

bind ret_addr_stack ras_chk #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .INSN_BYTES(INSN_BYTES)
) u_chk (.*);

// File: tb/ret_addr_stack_tb.sv
module ret_addr_stack_tb;
    localparam int AW = 32;
    localparam int DP = 16;
    localparam int IB = 4;
    localparam int PW = $clog2(DP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call_push_i = 0, ret_pop_i = 0, undo_pop_i = 0, restore_i = 0;
    logic [AW-1:0] call_pc_i = '0, rst_tgt_i = '0;
    logic [PW-1:0] rst_idx_i = '0;
    logic [AW-1:0] top_addr_o;
    logic [PW-1:0] top_idx_o;
    logic          ret_hit_o, empty_o;

    always #2.5 clk = ~clk;

    ret_addr_stack #(.ADDR_W(AW), .DEPTH(DP), .INSN_BYTES(IB)) u_dut (.*);

    // behavioural reference
    logic [AW-1:0] m_mem [DP];
    int            m_ptr, m_cnt;
    int            n_vec = 0, n_bad = 0;
    logic          done = 1'b0;

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_state(input string tag);
        chk({tag, " empty R9"}, AW'(empty_o), AW'(m_cnt == 0));
        chk({tag, " idx R7"},   AW'(top_idx_o), AW'(m_ptr));
        chk({tag, " top R3"},   top_addr_o, (m_cnt == 0) ? '0 : m_mem[m_ptr]);
    endtask

    task automatic cyc(input string tag, input logic ps, input logic [AW-1:0] pc,
                       input logic rp, input logic up, input logic rs,
                       input logic [PW-1:0] ri, input logic [AW-1:0] rt);
        call_push_i = ps; call_pc_i = pc; ret_pop_i = rp; undo_pop_i = up;
        restore_i = rs; rst_idx_i = ri; rst_tgt_i = rt;
        #1;
        chk({tag, " hit R3 R4"}, AW'(ret_hit_o), AW'(rp && m_cnt > 0));
        @(posedge clk);
        if (rs) begin                               // R8 restore first
            m_ptr = ri; m_mem[ri] = rt;
            if (m_cnt == 0) m_cnt = 1;              // R6
        end else if (ps) begin                      // R2, R7
            m_ptr = (m_ptr + 1) % DP; m_mem[m_ptr] = pc + IB;
            if (m_cnt < DP) m_cnt++;
        end else if ((rp || up) && m_cnt > 0) begin // R5
            m_ptr = (m_ptr + DP - 1) % DP; m_cnt--;
        end
        @(negedge clk);
        check_state(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++; n_vec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        m_ptr = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_state("R1 reset");
        // empty-stack return: no hit, nothing moves (R4)
        cyc("R4 pop empty", 0, 0, 1, 0, 0, 0, 0);
        cyc("R4 undo empty", 0, 0, 0, 1, 0, 0, 0);
        // pushes (R2)
        cyc("R2 push a", 1, 32'h1000, 0, 0, 0, 0, 0);
        cyc("R2 push b", 1, 32'h2000, 0, 0, 0, 0, 0);
        // return pop then restore of the saved checkpoint (R3, R6)
        cyc("R3 ret", 0, 0, 1, 0, 0, 0, 0);
        cyc("R2 younger push overwrites", 1, 32'h3000, 0, 0, 0, 0, 0);
        cyc("R6 restore", 0, 0, 0, 0, 1, 4'd2, 32'h2004);
        // both pops together act once (R5)
        cyc("R5 dual pop", 0, 0, 1, 1, 0, 0, 0);
        // collisions (R8)
        cyc("R8 restore+push", 1, 32'h4000, 0, 0, 1, 4'd9, 32'hABCD0000);
        cyc("R8 restore+ret", 0, 0, 1, 0, 1, 4'd5, 32'h5555AAAA);
        cyc("R8 push+pop", 1, 32'h6000, 1, 1, 0, 0, 0);
        // drain to empty, then restore from empty (R6)
        for (int i = 0; i < 20; i++) cyc("R5 drain", 0, 0, 0, 1, 0, 0, 0);
        cyc("R6 restore from empty", 0, 0, 0, 0, 1, 4'd15, 32'h0F0F0F0F);
        cyc("R5 pop after restore", 0, 0, 1, 0, 0, 0, 0);
        // fill past depth, wrap and saturate (R7)
        for (int i = 0; i < DP + 3; i++) cyc("R7 fill", 1, AW'(32'h100 * (i + 1)), 0, 0, 0, 0, 0);
        cyc("R8 restore when full", 0, 0, 0, 0, 1, 4'd3, 32'hFEEDBEEF);
        for (int i = 0; i < DP + 2; i++) cyc("R7 unwind", 0, 0, 1, 0, 0, 0, 0);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            cyc("R8 mixed", r[0], $urandom, r[1], r[2] & r[3], (r == 4'hF),
                4'($urandom), $urandom);
        end
        // reset mid-run (R1)
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1; m_ptr = 0; m_cnt = 0;
        #1;
        check_state("R1 re-reset");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule